// File: doc/BRIEF.md
# Edge-Difference Input Capture Timer

This block times events on one asynchronous input pin against a count enable that pulses once per instruction clock. The pin first passes through a synchronizer and an edge detector. In standard capture mode a free-running 16-bit down-counter is copied into a capture register whenever the chosen edge arrives. In difference mode the block waits for a chosen start edge, counts ticks from zero, and stores the count when a chosen stop edge arrives. The start and stop edges are selected independently, so any rising/falling pairing can be measured and no software subtraction is needed.

Two sticky flags record events. One marks a new capture and the other marks a counter underflow (standard mode) or saturation (difference mode). Each flag is cleared by a one-cycle write-one-to-clear pulse and can drive the interrupt line through its own enable. After each difference measurement the block re-arms by itself.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, cap_value is 0x0000 and cap_pend, unf_flag and irq are 0.
- R2: The pin passes through two synchronizer flops and an edge-detect flop. A pin level that is present before clock edge k is acted on at edge k+2: the capture register and cap_pend update at that edge and are visible after it.
- R3: Standard mode is selected by enable=1 and mode_diff=0. While enable=0 the counter is held at 0xFFFF. Whenever the configuration {enable, mode_diff} changes, one cycle is spent reloading the counter. In later cycles each tick decrements the counter by one. On the selected edge (edge_std 0 = rising, 1 = falling) the counter value before that cycle's tick is stored into cap_value and cap_pend is set.
- R4: In standard mode, a tick while the counter is 0x0000 wraps it to 0xFFFF and sets unf_flag.
- R5: Difference mode is selected by enable=1 and mode_diff=1. edge_first and edge_second each select 0 = rising or 1 = falling. The block waits for the start edge, then clears the counter and adds one per tick. On the stop edge it stores the counter (without that cycle's tick) into cap_value and sets cap_pend. With tick held high, a start-to-stop spacing of N clocks at the pin gives N-1.
- R6: In difference mode, the tick that brings the counter to 0xFFFF sets unf_flag, and the counter then holds at 0xFFFF. A later stop edge stores 0xFFFF.
- R7: After a difference capture the block returns to waiting. A fresh start edge is needed before the next measurement, and the stop edge that ended a measurement does not start a new one.
- R8: A cycle with clr_cap (clr_unf) high clears cap_pend (unf_flag). A set event in the same cycle takes priority over the clear.
- R9: irq is high exactly when (cap_pend and ie_cap) or (unf_flag and ie_unf).
- R10: Edges of the polarity that is not selected have no effect on cap_value or cap_pend. While enable=0, pin activity has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable |
| cap_pin | input | 1 | Asynchronous capture pin |
| enable | input | 1 | Enables the selected mode |
| mode_diff | input | 1 | 0 = standard capture, 1 = difference capture |
| edge_std | input | 1 | Standard-mode edge: 0 rising, 1 falling |
| edge_first | input | 1 | Difference start edge: 0 rising, 1 falling |
| edge_second | input | 1 | Difference stop edge: 0 rising, 1 falling |
| clr_cap | input | 1 | Write-one-to-clear pulse for cap_pend |
| clr_unf | input | 1 | Write-one-to-clear pulse for unf_flag |
| ie_cap | input | 1 | Interrupt enable for cap_pend |
| ie_unf | input | 1 | Interrupt enable for unf_flag |
| cap_value | output | 16 | Capture register |
| cap_pend | output | 1 | Capture pending flag |
| unf_flag | output | 1 | Underflow / saturation flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the local rules:
- the down-count step and the wrap from zero in standard mode;
- the hold at saturation in difference mode;
- the capture register staying unchanged when no capture happens;
- the clear and set priority of the flags;
- the spacing of edge pulses;
- the interrupt following a newly raised enabled flag.

Some behaviours need a sequence of pin activity and only the bench scenarios can show them. These are the three-cycle latency from pin to capture, the exact N-1 interval for each of the four edge pairings, re-arming after a measurement, and the full 65536-tick wrap and saturation. The bench runs a cycle-level reference model in lockstep with the design over both directed and random pin traffic.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic [1:0] {
    CFG_OFF  = 2'd0,
    CFG_STD  = 2'd1,
    CFG_DIFF = 2'd2
  } cfg_e;

  typedef enum logic {
    DS_WAIT = 1'b0,
    DS_RUN  = 1'b1
  } dstate_e;

  localparam int FLAG_CAP  = 0;
  localparam int FLAG_UNF  = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/ect_pin_sync.sv
module ect_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], pin_async};
    end else begin : g_single
      always_comb chain_d = pin_async;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[LAST];
    end
  end

  assign rise_o = chain_q[LAST] & ~prev_q;
  assign fall_o = ~chain_q[LAST] & prev_q;

  // R2
  rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R2
  fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ect_counter.sv
module ect_counter
  import ect_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         enable_i,
  input  logic         mode_diff_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         edge_std_i,
  input  logic         edge_first_i,
  input  logic         edge_second_i,
  output logic [W-1:0] cap_o,
  output logic         cap_evt_o,
  output logic         unf_evt_o
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ZERO     = '0;
  localparam logic [W-1:0] SAT_M1   = ALL_ONES - 1'b1;

  cfg_e        cfg_now, cfg_q;
  dstate_e     st_q, st_d;
  logic [W-1:0] cnt_q, cnt_d, cap_q;
  logic        reload, cap_we, unf_evt;
  logic        std_hit, first_hit, second_hit;

  always_comb begin
    if (!enable_i)       cfg_now = CFG_OFF;
    else if (mode_diff_i) cfg_now = CFG_DIFF;
    else                 cfg_now = CFG_STD;
  end

  assign reload     = (cfg_now != cfg_q) || (cfg_now == CFG_OFF);
  assign std_hit    = edge_std_i    ? fall_i : rise_i;
  assign first_hit  = edge_first_i  ? fall_i : rise_i;
  assign second_hit = edge_second_i ? fall_i : rise_i;

  always_comb begin
    cnt_d   = cnt_q;
    st_d    = st_q;
    cap_we  = 1'b0;
    unf_evt = 1'b0;
    if (reload) begin
      cnt_d = (cfg_now == CFG_DIFF) ? ZERO : ALL_ONES;
      st_d  = DS_WAIT;
    end else if (cfg_q == CFG_STD) begin
      cap_we = std_hit;
      if (tick_i) begin
        cnt_d   = cnt_q - 1'b1;
        unf_evt = (cnt_q == ZERO);
      end
    end else begin
      case (st_q)
        DS_WAIT: begin
          if (first_hit) begin
            st_d  = DS_RUN;
            cnt_d = ZERO;
          end
        end
        DS_RUN: begin
          if (second_hit) begin
            cap_we = 1'b1;
            st_d   = DS_WAIT;
          end else if (tick_i && (cnt_q != ALL_ONES)) begin
            cnt_d   = cnt_q + 1'b1;
            unf_evt = (cnt_q == SAT_M1);
          end
        end
        default: st_d = DS_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_OFF;
      st_q  <= DS_WAIT;
      cnt_q <= ALL_ONES;
    end else begin
      cfg_q <= cfg_now;
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= ZERO;
    else if (cap_we) cap_q <= cnt_q;
  end

  assign cap_o     = cap_q;
  assign cap_evt_o = cap_we;
  assign unf_evt_o = unf_evt;

  // R3
  std_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == CFG_STD && cfg_now == CFG_STD && tick_i)
      |=> cnt_q == $past(cnt_q) - 1'b1);

  // R4
  std_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == CFG_STD && cfg_now == CFG_STD && tick_i && cnt_q == ZERO)
      |=> cnt_q == ALL_ONES);

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == CFG_DIFF && cfg_now == CFG_DIFF && st_q == DS_RUN &&
     cnt_q == ALL_ONES && !second_hit) |=> cnt_q == ALL_ONES);

  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_we |=> $stable(cap_q));
endmodule

// File: rtl/ect_flags.sv
module ect_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_flag
      logic bit_q, bit_d;

      always_comb bit_d = set_i[g] | (bit_q & ~clr_i[g]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end

      assign flag_o[g] = bit_q;

      // R8
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
    end
  endgenerate

  assign irq_o = |(flag_o & ie_i);
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cap_pin,
  input  logic             enable,
  input  logic             mode_diff,
  input  logic             edge_std,
  input  logic             edge_first,
  input  logic             edge_second,
  input  logic             clr_cap,
  input  logic             clr_unf,
  input  logic             ie_cap,
  input  logic             ie_unf,
  output logic [WIDTH-1:0] cap_value,
  output logic             cap_pend,
  output logic             unf_flag,
  output logic             irq
);
  logic                 rise, fall, cap_evt, unf_evt;
  logic [NUM_FLAGS-1:0] f_set, f_clr, f_ie, f_q;

  ect_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(cap_pin),
    .rise_o(rise), .fall_o(fall)
  );

  ect_counter #(.W(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .enable_i(enable),
    .mode_diff_i(mode_diff), .rise_i(rise), .fall_i(fall),
    .edge_std_i(edge_std), .edge_first_i(edge_first),
    .edge_second_i(edge_second), .cap_o(cap_value),
    .cap_evt_o(cap_evt), .unf_evt_o(unf_evt)
  );

  always_comb begin
    f_set = '0;
    f_clr = '0;
    f_ie  = '0;
    f_set[FLAG_CAP] = cap_evt;
    f_set[FLAG_UNF] = unf_evt;
    f_clr[FLAG_CAP] = clr_cap;
    f_clr[FLAG_UNF] = clr_unf;
    f_ie[FLAG_CAP]  = ie_cap;
    f_ie[FLAG_UNF]  = ie_unf;
  end

  ect_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(f_set), .clr_i(f_clr),
    .ie_i(f_ie), .flag_o(f_q), .irq_o(irq)
  );

  assign cap_pend = f_q[FLAG_CAP];
  assign unf_flag = f_q[FLAG_UNF];

  // R9
  irq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_pend) && ie_cap) |-> irq);

  // R9
  irq_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(unf_flag) && ie_unf) |-> irq);
endmodule

// File: tb/edge_capture_timer_bench.sv
`timescale 1ns/1ps
module edge_capture_timer_bench;
  logic clk = 1'b0;
  logic rst_n, tick, cap_pin, enable, mode_diff, edge_std, edge_first, edge_second;
  logic clr_cap, clr_unf, ie_cap, ie_unf;
  logic [15:0] cap_value;
  logic cap_pend, unf_flag, irq;

  int n_chk = 0, n_fail = 0;
  bit checking = 0, reported = 0;

  always #2 clk = ~clk;

  edge_capture_timer u_edge_capture_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_pin), .enable(enable),
    .mode_diff(mode_diff), .edge_std(edge_std), .edge_first(edge_first),
    .edge_second(edge_second), .clr_cap(clr_cap), .clr_unf(clr_unf),
    .ie_cap(ie_cap), .ie_unf(ie_unf), .cap_value(cap_value),
    .cap_pend(cap_pend), .unf_flag(unf_flag), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
    $finish;
  endtask

  // Reference model of the requirements
  bit m_s1, m_s2, m_p, m_run, m_pend, m_unf;
  int m_cfg;
  logic [15:0] m_cnt, m_cap;

  function automatic bit pick(bit sel, bit r, bit f);
    return sel ? f : r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_p = 0; m_run = 0; m_pend = 0; m_unf = 0;
      m_cfg = 0; m_cnt = 16'hFFFF; m_cap = 0;
    end else begin
      bit r, f, cset, uset;
      int now;
      r = m_s2 & ~m_p;
      f = ~m_s2 & m_p;
      cset = 0; uset = 0;
      now = !enable ? 0 : (mode_diff ? 2 : 1);
      if (now != m_cfg || now == 0) begin
        m_cnt = (now == 2) ? 16'h0000 : 16'hFFFF;
        m_run = 0;
      end else if (now == 1) begin
        if (pick(edge_std, r, f)) begin m_cap = m_cnt; cset = 1; end
        if (tick) begin
          if (m_cnt == 0) uset = 1;
          m_cnt = m_cnt - 16'd1;
        end
      end else if (!m_run) begin
        if (pick(edge_first, r, f)) begin m_run = 1; m_cnt = 0; end
      end else begin
        if (pick(edge_second, r, f)) begin
          m_cap = m_cnt; cset = 1; m_run = 0;
        end else if (tick && m_cnt != 16'hFFFF) begin
          m_cnt = m_cnt + 16'd1;
          if (m_cnt == 16'hFFFF) uset = 1;
        end
      end
      m_pend = cset | (m_pend & ~clr_cap);
      m_unf  = uset | (m_unf & ~clr_unf);
      m_p = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
      m_cfg = now;
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(mode_diff ? "R5 cap_value" : "R3 cap_value", cap_value, m_cap);
      chk("R8 cap_pend", cap_pend, m_pend);
      chk(mode_diff ? "R6 unf_flag" : "R4 unf_flag", unf_flag, m_unf);
      chk("R9 irq", irq, (m_pend & ie_cap) | (m_unf & ie_unf));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_cap();
    clr_cap = 1; cyc(1); clr_cap = 0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; tick = 0; cap_pin = 0; enable = 0; mode_diff = 0; edge_std = 0;
    edge_first = 0; edge_second = 0; clr_cap = 0; clr_unf = 0; ie_cap = 1; ie_unf = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 cap_value", cap_value, 0);
    chk("R1 cap_pend", cap_pend, 0);
    chk("R1 unf_flag", unf_flag, 0);
    chk("R1 irq", irq, 0);
    checking = 1;

    // R5 rise->fall, R2 latency
    cyc(1); enable = 1; mode_diff = 1; edge_first = 0; edge_second = 1; tick = 1;
    cyc(5); clear_cap(); cyc(2);
    cap_pin = 1; cyc(20); cap_pin = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R2 pend before latency", cap_pend, 0);
    @(posedge clk);
    @(negedge clk); chk("R2 pend at latency", cap_pend, 1);
    chk("R5 rise-fall width", cap_value, 19);
    chk("R9 irq on pend", irq, 1);
    ie_cap = 0; #0.5; chk("R9 irq masked", irq, 0); ie_cap = 1;

    // R8 clear, R7 re-arm with second pulse
    @(posedge clk); #1; clear_cap();
    @(negedge clk); chk("R8 pend cleared", cap_pend, 0);
    cyc(3); cap_pin = 1; cyc(7); cap_pin = 0; cyc(3);
    @(negedge clk); chk("R7 second measurement", cap_value, 6);

    // R5 rise->rise
    @(posedge clk); #1; edge_second = 0; clear_cap(); cyc(3);
    cap_pin = 1; cyc(3); cap_pin = 0; cyc(5); cap_pin = 1; cyc(3);
    @(negedge clk); chk("R5 rise-rise", cap_value, 7);

    // R5 fall->fall
    @(posedge clk); #1; edge_first = 1; edge_second = 1; cyc(3);
    cap_pin = 0; cyc(4); cap_pin = 1; cyc(2); cap_pin = 0; cyc(3);
    @(negedge clk); chk("R5 fall-fall", cap_value, 5);

    // R5 fall->rise, with a leading rise that must not start it (R7)
    @(posedge clk); #1; edge_second = 0; cyc(3);
    cap_pin = 1; cyc(4); cap_pin = 0; cyc(9); cap_pin = 1; cyc(3);
    @(negedge clk); chk("R5 fall-rise", cap_value, 8);

    // R10 unselected edge in standard mode, then disabled
    @(posedge clk); #1; mode_diff = 0; edge_std = 0; cyc(3); clear_cap();
    cap_pin = 0; cyc(5);
    @(negedge clk); chk("R10 falling ignored", cap_pend, 0);
    chk("R10 cap unchanged", cap_value, 8);
    @(posedge clk); #1; cap_pin = 1; cyc(4);
    @(negedge clk); chk("R3 rising captured", cap_pend, 1);
    @(posedge clk); #1; enable = 0; clear_cap();
    cap_pin = 0; cyc(4); cap_pin = 1; cyc(4);
    @(negedge clk); chk("R10 disabled ignores pin", cap_pend, 0);

    // R4 full wrap in standard mode
    @(posedge clk); #1; enable = 1; clr_unf = 1; cyc(1); clr_unf = 0;
    cyc(100);
    @(negedge clk); chk("R4 no early underflow", unf_flag, 0);
    @(posedge clk); #1; cyc(65440);
    @(negedge clk); chk("R4 wrap sets flag", unf_flag, 1);

    // R6 saturation in difference mode
    @(posedge clk); #1; mode_diff = 1; edge_first = 0; edge_second = 0;
    cap_pin = 0; clr_unf = 1; cyc(1); clr_unf = 0; cyc(4);
    cap_pin = 1; cyc(3); cap_pin = 0; cyc(66000);
    @(negedge clk); chk("R6 saturation flag", unf_flag, 1);
    @(posedge clk); #1; cap_pin = 1; cyc(4);
    @(negedge clk); chk("R6 saturated capture", cap_value, 16'hFFFF);

    // Random traffic against the model
    @(posedge clk); #1;
    for (int i = 0; i < 15000; i++) begin
      if (i % 500 == 0) begin
        enable = ($urandom % 8) != 0;
        mode_diff = $urandom % 2;
        edge_std = $urandom % 2;
        edge_first = $urandom % 2;
        edge_second = $urandom % 2;
      end
      if (i % 32 == 0) begin
        ie_cap = $urandom % 2;
        ie_unf = $urandom % 2;
      end
      tick = ($urandom % 4) != 0;
      if ($urandom % 6 == 0) cap_pin = ~cap_pin;
      clr_cap = ($urandom % 16) == 0;
      clr_unf = ($urandom % 16) == 0;
      cyc(1);
    end
    @(negedge clk);
    report();
  end
endmodule